// File: doc/BRIEF.md
# Multi-Mode Self-Test Register

This block is one register of configurable width that can play four different roles in built-in self test. A two-bit mode input chooses the role. In latch mode it is an ordinary parallel register. In scan mode it is a serial shift chain. In pattern mode it runs as a maximal-length linear feedback shift register and feeds pseudo-random words to logic downstream. In compaction mode it folds each parallel input word into its running contents and builds a checksum of a response stream.

A typical test arrangement uses two copies around a block of combinational logic. The copy in front runs in pattern mode and drives the logic. The copy behind it runs in compaction mode and absorbs the logic's outputs. After a known number of cycles, the contents of the second copy are compared with a signature computed ahead of time. The mode input is sampled at every rising clock edge, so the mode present before an edge decides the update made on that edge. The four modes can be seen as the states of a small machine, and the controller outside the block picks the state. Mode transitions: latch, scan, pattern and compaction can each go to any other mode at any edge, and reset always returns the contents to the seed.

Top module: `selftest_reg`

## Requirements
- R1: A synchronous, active-high reset loads the seed value 8'h01 (the parameter SEED) on the next rising edge, whatever the mode.
- R2: Mode 2'b00 (latch): on each edge the register takes the parallel input word unchanged, and the parallel output shows it.
- R3: Mode 2'b01 (scan): on each edge the contents move up one bit position, the serial input enters bit 0, and the old bit W-1 is lost.
- R4: Mode 2'b10 (pattern): on each edge the contents move up one bit and bit 0 takes the XOR of bits 7, 5, 4 and 3 (the polynomial x^8+x^6+x^5+x^4+1). The parallel and serial inputs have no effect.
- R5: Starting from the seed in pattern mode, the register never holds zero and first returns to the seed after exactly 255 edges.
- R6: Mode 2'b11 (compaction): the next value is the pattern-mode next value XORed bit by bit with the parallel input word.
- R7: The serial output equals the most significant register bit in every mode.
- R8: The signature output equals the full register contents in every mode.
- R9: A mode change takes effect at the first edge after the new mode is applied. When the mode changes on every cycle, each update follows the mode that was present just before its edge.
- R10: A pattern-mode copy that drives a combinational function, with its outputs compacted by a second copy, yields the expected signature after a fixed run. Corrupting a single response word yields a different signature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset to SEED |
| mode_i | input | 2 | 00 latch, 01 scan, 10 pattern, 11 compaction |
| par_i | input | WIDTH | Parallel data / response word |
| ser_i | input | 1 | Serial scan input |
| par_o | output | WIDTH | Register contents |
| ser_o | output | 1 | Most significant register bit |
| sig_o | output | WIDTH | Signature (register contents) |

## Verification
Each mode is driven with a changing stream of parallel words and serial bits. In pattern mode this shows that the inputs are ignored, and in latch and compaction mode it shows that every input bit is used. A run in which the mode changes on every cycle separates correct mode timing from a one-cycle slip. A full pattern period from the seed confirms the tap set and that the register never locks up in the all-zero state. A generator-to-compactor pair, run once clean and once with a single corrupted response word, shows that the signature catches a fault in one word.

// File: rtl/selftest_pkg.sv
package selftest_pkg;

    typedef enum logic [1:0] {
        MODE_LATCH   = 2'b00,
        MODE_SCAN    = 2'b01,
        MODE_PATTERN = 2'b10,
        MODE_COMPACT = 2'b11
    } mode_e;

endpackage

// File: rtl/str_feedback.sv
module str_feedback #(
    parameter int WIDTH = 8,
    parameter logic [WIDTH-1:0] TAPS = 8'hB8
) (
    input  logic [WIDTH-1:0] state_i,
    output logic             fb_o
);
    logic [WIDTH-1:0] masked;

    // one AND term per bit position, selected by the tap mask
    for (genvar i = 0; i < WIDTH; i++) begin : g_tap
        if (TAPS[i]) begin : g_on
            assign masked[i] = state_i[i];
        end else begin : g_off
            assign masked[i] = 1'b0;
        end
    end

    assign fb_o = ^masked;
endmodule

// File: rtl/str_nextstate.sv
module str_nextstate
    import selftest_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  mode_e            mode_i,
    input  logic [WIDTH-1:0] state_i,
    input  logic [WIDTH-1:0] par_i,
    input  logic             ser_i,
    input  logic             fb_i,
    output logic [WIDTH-1:0] next_o
);
    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] lfsr_step;
    assign lfsr_step = {state_i[TOP-1:0], fb_i};

    always_comb begin
        unique case (mode_i)
            MODE_LATCH:   next_o = par_i;
            MODE_SCAN:    next_o = {state_i[TOP-1:0], ser_i};
            MODE_PATTERN: next_o = lfsr_step;
            MODE_COMPACT: next_o = lfsr_step ^ par_i;
            default:      next_o = par_i;
        endcase
    end
endmodule

// File: rtl/selftest_reg.sv
module selftest_reg
    import selftest_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter logic [WIDTH-1:0] TAPS = 8'hB8,
    parameter logic [WIDTH-1:0] SEED = 8'h01
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_i,
    input  logic [WIDTH-1:0] par_i,
    input  logic             ser_i,
    output logic [WIDTH-1:0] par_o,
    output logic             ser_o,
    output logic [WIDTH-1:0] sig_o
);
    localparam int TOP = WIDTH - 1;

    mode_e            mode;
    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_d;
    logic             fb;

    assign mode = mode_e'(mode_i);

    str_feedback #(.WIDTH(WIDTH), .TAPS(TAPS)) u_fb (
        .state_i (state_q),
        .fb_o    (fb)
    );

    str_nextstate #(.WIDTH(WIDTH)) u_next (
        .mode_i  (mode),
        .state_i (state_q),
        .par_i   (par_i),
        .ser_i   (ser_i),
        .fb_i    (fb),
        .next_o  (state_d)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= SEED;
        else     state_q <= state_d;
    end

    // outputs
    always_comb begin
        par_o = state_q;
        sig_o = state_q;
        ser_o = state_q[TOP];
    end

    assert_reset_seed_R1: assert property (@(posedge clk)
        rst |=> (par_o == SEED));

    assert_latch_capture_R2: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b00) |=> (par_o == $past(par_i)));

    assert_scan_shift_R3: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b01) |=> (par_o == {$past(par_o[TOP-1:0]), $past(ser_i)}));

    assert_pattern_shift_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b10) |=> (par_o[TOP:1] == $past(par_o[TOP-1:0])));

    assert_pattern_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b10 && par_o != '0) |=> (par_o != '0));

    assert_compact_fold_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b11) |=> ((par_o[TOP:1] ^ $past(par_i[TOP:1])) == $past(par_o[TOP-1:0])));
endmodule

// File: tb/selftest_reg_test.sv
module selftest_reg_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [7:0] pin = 8'h00;
    logic       sin = 1'b0;
    logic [7:0] pout, sig;
    logic       sout;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [7:0] exp_q;
    int lcg = 12345;

    always #(CLK_PERIOD/2) clk = ~clk;

    selftest_reg uut (
        .clk(clk), .rst(rst), .mode_i(mode), .par_i(pin), .ser_i(sin),
        .par_o(pout), .ser_o(sout), .sig_o(sig)
    );

    // generator / compactor pair around a small function
    logic       prst = 1'b0;
    logic [7:0] gq, gsig, cq, csig, fault_mask = 8'h00, resp;
    logic       gso, cso;

    function automatic logic [7:0] cut(logic [7:0] x);
        return {x[3:0], x[7:4]} ^ (x << 1) ^ 8'h5A;
    endfunction

    always_comb resp = cut(gq) ^ fault_mask;

    selftest_reg gen_u (
        .clk(clk), .rst(prst), .mode_i(2'b10), .par_i(8'h00), .ser_i(1'b0),
        .par_o(gq), .ser_o(gso), .sig_o(gsig)
    );
    selftest_reg cmp_u (
        .clk(clk), .rst(prst), .mode_i(2'b11), .par_i(resp), .ser_i(1'b0),
        .par_o(cq), .ser_o(cso), .sig_o(csig)
    );

    function automatic logic [7:0] model(logic [1:0] m, logic [7:0] q, logic [7:0] d, logic s);
        logic fb;
        fb = q[7] ^ q[5] ^ q[4] ^ q[3];
        case (m)
            2'b00:   return d;
            2'b01:   return {q[6:0], s};
            2'b10:   return {q[6:0], fb};
            default: return {q[6:0], fb} ^ d;
        endcase
    endfunction

    task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] rnd8();
        lcg = lcg * 1103515245 + 12345;
        return lcg[23:16];
    endfunction

    // apply inputs at negedge, update model at posedge, compare at next negedge
    task automatic step(logic [1:0] m, logic [7:0] d, logic s, string tag);
        mode = m; pin = d; sin = s;
        @(posedge clk);
        exp_q = rst ? 8'h01 : model(m, exp_q, d, s);
        @(negedge clk);
        check(tag, pout, exp_q);
        check("R7", {7'd0, sout}, {7'd0, exp_q[7]});
        check("R8", sig, exp_q);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] clean_sig;
        logic [7:0] pg, ps;
        int period;
        bit saw_zero;
        @(negedge clk);
        // R1: reset from latch mode with a non-seed input
        rst = 1'b1;
        step(2'b00, 8'hEE, 1'b1, "R1");
        rst = 1'b0;

        // R2: latch several patterns
        step(2'b00, 8'hA5, 1'b0, "R2");
        step(2'b00, 8'h00, 1'b1, "R2");
        step(2'b00, 8'hFF, 1'b0, "R2");
        for (int i = 0; i < 8; i++) step(2'b00, rnd8(), 1'b0, "R2");

        // R3: scan a walking pattern in and out
        step(2'b00, 8'h81, 1'b0, "R2");
        for (int i = 0; i < 12; i++) step(2'b01, rnd8(), (i % 3) == 0, "R3");

        // R4: pattern mode ignores parallel and serial inputs
        for (int i = 0; i < 20; i++) step(2'b10, rnd8(), i[0], "R4");

        // R6: compaction of a varied stream
        for (int i = 0; i < 20; i++) step(2'b11, rnd8(), 1'b0, "R6");

        // R9: mode changes on every cycle
        for (int i = 0; i < 24; i++) step(2'(i % 4), rnd8(), i[1], "R9");
        for (int i = 0; i < 16; i++) step(2'(3 - (i % 4)), rnd8(), i[0], "R9");

        // R1 again from compaction mode, then R5 full period from the seed
        rst = 1'b1;
        step(2'b11, 8'h3C, 1'b1, "R1");
        rst = 1'b0;
        period = 0; saw_zero = 0;
        for (int i = 1; i <= 255; i++) begin
            step(2'b10, rnd8(), 1'b1, "R5");
            if (pout == 8'h00) saw_zero = 1;
            if (pout == 8'h01 && period == 0) period = i;
        end
        check("R5 period", 8'(period), 8'd255);
        check("R5 nonzero", {7'd0, saw_zero}, 8'h00);

        // R10: generator / compactor pair, clean run
        prst = 1'b1; @(posedge clk); @(negedge clk); prst = 1'b0;
        pg = 8'h01; ps = 8'h01;
        for (int i = 0; i < 60; i++) begin
            @(posedge clk);
            ps = model(2'b11, ps, cut(pg), 1'b0);
            pg = model(2'b10, pg, 8'h00, 1'b0);
            @(negedge clk);
            check("R10 gen", gq, pg);
            check("R10 sig", csig, ps);
        end
        clean_sig = csig;

        // R10: same run with one corrupted response word
        prst = 1'b1; @(posedge clk); @(negedge clk); prst = 1'b0;
        for (int i = 0; i < 60; i++) begin
            fault_mask = (i == 20) ? 8'h04 : 8'h00;
            @(posedge clk);
            @(negedge clk);
        end
        fault_mask = 8'h00;
        checks++;
        if (csig === clean_sig) begin
            fails++;
            $display("FAIL R10 fault: got %h expected value other than %h", csig, clean_sig);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule